// File: doc/BRIEF.md
# Thresholded Byte FIFO Pair

This block sits between a 32-bit register port and a byte-serial shift engine. It keeps two byte queues of eight entries each: a transmit queue that software fills through a data-out register write and the shifter drains one byte per pop, and a receive queue that the shifter fills one byte per push and software drains through a data-in register read. A mode input selects whether each register access moves one byte or four; in four-byte mode the bytes are packed little-endian, so bits [7:0] are the first byte on the wire in either direction.

Each queue reports its full and empty state, a ready flag compared against a 3-bit programmable threshold, and sticky overflow and underflow flags. A flush command empties both queues and clears the sticky flags, then drops its own busy flag so software can poll for completion. A held soft-reset input returns everything to the reset state.

Top module: `word_fifo_pair`

## Requirements
- R1: While `soft_rst` is high, and after `rst_n` reset, both queues are empty, all four sticky flags are 0 and `flush_busy` is 0, so that `tx_empty`=1, `rx_empty`=1 and `tx_ready`=1 when `wr_thr` < 8.
- R2: With `wide_mode`=0, a data-out write queues only `dout_wdata[7:0]`; bytes leave on `tx_byte` in write order, one per `tx_pop`.
- R3: With `wide_mode`=1, a data-out write queues four bytes taken from `dout_wdata` in the order [7:0], [15:8], [23:16], [31:24].
- R4: With `wide_mode`=1, a data-in read returns four received bytes with the earliest in bits [7:0]; with `wide_mode`=0 it returns one byte in bits [7:0] and zero in bits [31:8].
- R5: `tx_ready` is 1 exactly when the free bytes in the transmit queue exceed `wr_thr`; `rx_ready` is 1 exactly when the bytes held in the receive queue exceed `rd_thr`.
- R6: `tx_full` is 1 when the transmit queue has fewer free bytes than one access (1 or 4); `tx_empty` is 1 when it holds no byte; `rx_full` is 1 when the receive queue holds 8 bytes; `rx_empty` is 1 when it holds fewer bytes than one access.
- R7: A data-out write while `tx_full` is 1 queues nothing and sets `tx_ovf`.
- R8: A data-in read while `rx_empty` is 1 returns zero, removes nothing and sets `rx_unf`.
- R9: A `tx_pop` while `tx_empty` is 1 shows zero on `tx_byte` and sets `tx_unf`; an `rx_push` while `rx_full` is 1 drops the byte and sets `rx_ovf`.
- R10: Each sticky flag, once set, stays set until a flush completes or `soft_rst` is applied.
- R11: A one-cycle `flush_go` makes `flush_busy` 1 after the next clock edge; at the edge after that both queues become empty, the sticky flags clear and `flush_busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset, effective while held |
| flush_go | input | 1 | Starts a flush of both queues |
| flush_busy | output | 1 | High while a flush is pending; self-clearing |
| wide_mode | input | 1 | 1: four bytes per register access, 0: one byte |
| rd_thr | input | 3 | Receive ready threshold |
| wr_thr | input | 3 | Transmit ready threshold |
| dout_we | input | 1 | Data-out register write strobe |
| dout_wdata | input | 32 | Data-out register write value |
| din_re | input | 1 | Data-in register read strobe |
| din_rdata | output | 32 | Data-in register read value |
| tx_pop | input | 1 | Shifter takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter delivers one received byte |
| rx_byte | input | 8 | Received byte |
| tx_full | output | 1 | No room for one access in the transmit queue |
| tx_empty | output | 1 | Transmit queue holds no byte |
| tx_ready | output | 1 | Transmit free space above threshold |
| tx_ovf | output | 1 | Sticky: write to a full transmit queue |
| tx_unf | output | 1 | Sticky: pop from an empty transmit queue |
| rx_full | output | 1 | Receive queue holds 8 bytes |
| rx_empty | output | 1 | Receive queue holds less than one access |
| rx_ready | output | 1 | Receive fill above threshold |
| rx_ovf | output | 1 | Sticky: push into a full receive queue |
| rx_unf | output | 1 | Sticky: read from an empty receive queue |

## Verification
The assertions take for granted that every strobe and the mode and threshold inputs hold known values once reset is released, and that `wide_mode` does not change while a queue holds a partial access. The stimulus changes inputs only on the falling clock edge, keeps each strobe high for exactly one cycle, and changes `wide_mode` only after a flush or soft reset has emptied both queues.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
   localparam int BYTE_W = 8;

   // Bytes moved by one register access in the selected mode.
   function automatic int access_bytes(input logic wide, input int lanes);
      return wide ? lanes : 1;
   endfunction
endpackage

// File: rtl/err_latch.sv
module err_latch #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set,
   output logic [N-1:0] q
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q[i] <= 1'b0;
            else if (clr) q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
         end

         // R10: a set flag holds until cleared
         a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr) |=> q[i]);
      end
   endgenerate
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
   parameter int DEPTH = 8,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1,
   localparam int NW = $clog2(LANES + 1),
   localparam int DW = LANES * fifo_pair_pkg::BYTE_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push_en,
   input  logic [NW-1:0] push_n,
   input  logic [DW-1:0] push_data,
   input  logic          pop_en,
   input  logic [NW-1:0] pop_n,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count
);
   import fifo_pair_pkg::*;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("byte_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < LANES) begin : g_bad_lanes
      $error("byte_fifo: DEPTH must hold at least one full access");
   end

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     rd_ptr;
   logic [AW-1:0]     wr_ptr;
   logic [NW-1:0]     push_amt, pop_amt;

   assign wr_ptr   = rd_ptr + AW'(count);
   assign push_amt = push_en ? push_n : '0;
   assign pop_amt  = pop_en  ? pop_n  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         rd_ptr <= rd_ptr + AW'(pop_amt);
         count  <= count + CW'(push_amt) - CW'(pop_amt);
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic [AW-1:0] w_idx, r_idx;
         assign w_idx = wr_ptr + AW'(k);
         assign r_idx = rd_ptr + AW'(k);

         always_ff @(posedge clk) begin
            if (push_en && !clear && (int'(push_n) > k))
               mem[w_idx] <= push_data[k*BYTE_W +: BYTE_W];
         end

         assign head[k*BYTE_W +: BYTE_W] = mem[r_idx];
      end
   endgenerate

   // R6: occupancy never exceeds the storage
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);
   // R7: the caller only pushes into free space
   a_r7_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
      push_en |-> (int'(push_n) <= DEPTH - int'(count)));
   // R8: the caller only pops bytes that are present
   a_r8_pop_fits: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (int'(pop_n) <= int'(count)));
endmodule

// File: rtl/word_fifo_pair.sv
module word_fifo_pair #(
   parameter int DEPTH = 8,
   parameter int DATA_W = 32,
   parameter int THR_W = 3,
   localparam int LANES = DATA_W / 8,
   localparam int CW = $clog2(DEPTH) + 1,
   localparam int NW = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              flush_go,
   output logic              flush_busy,
   input  logic              wide_mode,
   input  logic [THR_W-1:0]  rd_thr,
   input  logic [THR_W-1:0]  wr_thr,
   input  logic              dout_we,
   input  logic [DATA_W-1:0] dout_wdata,
   input  logic              din_re,
   output logic [DATA_W-1:0] din_rdata,
   input  logic              tx_pop,
   output logic [7:0]        tx_byte,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              tx_ready,
   output logic              tx_ovf,
   output logic              tx_unf,
   output logic              rx_full,
   output logic              rx_empty,
   output logic              rx_ready,
   output logic              rx_ovf,
   output logic              rx_unf
);
   import fifo_pair_pkg::*;

   if (DATA_W % BYTE_W != 0) begin : g_bad_width
      $error("word_fifo_pair: DATA_W must be a whole number of bytes");
   end
   if ((1 << THR_W) < DEPTH) begin : g_bad_thr
      $error("word_fifo_pair: THR_W too narrow for DEPTH");
   end

   logic [NW-1:0]     acc_n;
   logic              clr;
   logic [CW-1:0]     tx_cnt, rx_cnt;
   logic [DATA_W-1:0] tx_head, rx_head;
   logic [DATA_W-1:0] tx_in, rx_in;
   logic [3:0]        err_set, err_q;

   assign acc_n = NW'(access_bytes(wide_mode, LANES));
   assign clr   = soft_rst | flush_busy;

   // Flush command: set by the request, cleared by the block one cycle later.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flush_busy <= 1'b0;
      else if (soft_rst)   flush_busy <= 1'b0;
      else if (flush_busy) flush_busy <= 1'b0;
      else if (flush_go)   flush_busy <= 1'b1;
   end

   // Level flags
   assign tx_empty = (tx_cnt == '0);
   assign tx_full  = (DEPTH - int'(tx_cnt)) < int'(acc_n);
   assign tx_ready = (DEPTH - int'(tx_cnt)) > int'(wr_thr);
   assign rx_full  = (int'(rx_cnt) == DEPTH);
   assign rx_empty = int'(rx_cnt) < int'(acc_n);
   assign rx_ready = int'(rx_cnt) > int'(rd_thr);

   // Mode-dependent packing on the register side
   generate
      if (LANES > 1) begin : g_multi
         assign tx_in = wide_mode ? dout_wdata
                                  : {{(DATA_W-BYTE_W){1'b0}}, dout_wdata[BYTE_W-1:0]};
         assign rx_in = {{(DATA_W-BYTE_W){1'b0}}, rx_byte};
         always_comb begin
            if (rx_empty)       din_rdata = '0;
            else if (wide_mode) din_rdata = rx_head;
            else                din_rdata = {{(DATA_W-BYTE_W){1'b0}}, rx_head[BYTE_W-1:0]};
         end
      end else begin : g_single
         assign tx_in     = dout_wdata;
         assign rx_in     = rx_byte;
         assign din_rdata = rx_empty ? '0 : rx_head;
      end
   endgenerate

   assign tx_byte = tx_empty ? 8'h00 : tx_head[BYTE_W-1:0];

   byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clr),
      .push_en   (dout_we && !tx_full),
      .push_n    (acc_n),
      .push_data (tx_in),
      .pop_en    (tx_pop && !tx_empty),
      .pop_n     (NW'(1)),
      .head      (tx_head),
      .count     (tx_cnt)
   );

   byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clr),
      .push_en   (rx_push && !rx_full),
      .push_n    (NW'(1)),
      .push_data (rx_in),
      .pop_en    (din_re && !rx_empty),
      .pop_n     (acc_n),
      .head      (rx_head),
      .count     (rx_cnt)
   );

   assign err_set = {din_re && rx_empty, rx_push && rx_full,
                     tx_pop && tx_empty, dout_we && tx_full};

   err_latch #(.N(4)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .set   (err_set),
      .q     (err_q)
   );

   assign tx_ovf = err_q[0];
   assign tx_unf = err_q[1];
   assign rx_ovf = err_q[2];
   assign rx_unf = err_q[3];

   // R11: flush busy lasts a single cycle
   a_r11_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> !flush_busy);
   // R11: a pending flush leaves both queues empty and flags clear
   a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |=> (tx_cnt == '0 && rx_cnt == '0 && err_q == '0));
   // R1: soft reset empties everything
   a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (tx_empty && rx_cnt == '0 && err_q == '0 && !flush_busy));
   // R7: a write into a full queue leaves its occupancy unchanged
   a_r7_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_we && tx_full && !tx_pop && !clr) |=> (tx_cnt == $past(tx_cnt)) && tx_ovf);
   // R8: a read of an empty queue returns zero
   a_r8_zero_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (din_re && rx_empty) |-> (din_rdata == '0));
endmodule

// File: tb/test_word_fifo_pair.sv
module test_word_fifo_pair;
   localparam time CYC = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0, flush_go = 1'b0, flush_busy;
   logic        wide_mode = 1'b0;
   logic [2:0]  rd_thr = 3'd0, wr_thr = 3'd6;
   logic        dout_we = 1'b0;
   logic [31:0] dout_wdata = '0;
   logic        din_re = 1'b0;
   logic [31:0] din_rdata;
   logic        tx_pop = 1'b0;
   logic [7:0]  tx_byte;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic tx_full, tx_empty, tx_ready, tx_ovf, tx_unf;
   logic rx_full, rx_empty, rx_ready, rx_ovf, rx_unf;

   int total = 0;
   int bad = 0;

   always #(CYC/2) clk = ~clk;

   word_fifo_pair i_word_fifo_pair (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush_go(flush_go),
      .flush_busy(flush_busy), .wide_mode(wide_mode), .rd_thr(rd_thr),
      .wr_thr(wr_thr), .dout_we(dout_we), .dout_wdata(dout_wdata),
      .din_re(din_re), .din_rdata(din_rdata), .tx_pop(tx_pop),
      .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
      .tx_full(tx_full), .tx_empty(tx_empty), .tx_ready(tx_ready),
      .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_full(rx_full),
      .rx_empty(rx_empty), .rx_ready(rx_ready), .rx_ovf(rx_ovf),
      .rx_unf(rx_unf)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr_word(input logic [31:0] d);
      dout_we = 1'b1; dout_wdata = d;
      @(negedge clk);
      dout_we = 1'b0;
   endtask

   task automatic pop_tx(output logic [7:0] b);
      tx_pop = 1'b1; #1 b = tx_byte;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic rd_word(output logic [31:0] v);
      din_re = 1'b1; #1 v = din_rdata;
      @(negedge clk);
      din_re = 1'b0;
   endtask

   task automatic do_soft_reset();
      soft_rst = 1'b1;
      repeat (3) @(negedge clk);
      soft_rst = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 tx_empty", 32'(tx_empty), 1);
      chk("R1 rx_empty", 32'(rx_empty), 1);
      chk("R1 tx_ready", 32'(tx_ready), 1);
      chk("R1 rx_ready", 32'(rx_ready), 0);
      chk("R1 flags", {28'd0, tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
      chk("R1 flush_busy", 32'(flush_busy), 0);
   endtask

   task automatic t_byte_tx();
      logic [7:0] b;
      wide_mode = 1'b0; wr_thr = 3'd6;
      wr_word(32'hFFFF_FF11);
      chk("R5 tx_ready free7", 32'(tx_ready), 1);
      wr_word(32'hABCD_EF22);
      chk("R5 tx_ready free6", 32'(tx_ready), 0);
      pop_tx(b); chk("R2 first byte", 32'(b), 32'h11);
      pop_tx(b); chk("R2 second byte", 32'(b), 32'h22);
      chk("R6 tx_empty after drain", 32'(tx_empty), 1);
   endtask

   task automatic t_wide_tx();
      logic [7:0] b;
      logic [7:0] exp_b [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
      wide_mode = 1'b1; wr_thr = 3'd3;
      wr_word(32'h4433_2211);
      chk("R5 tx_ready free4", 32'(tx_ready), 1);
      wr_word(32'h8877_6655);
      chk("R6 tx_full", 32'(tx_full), 1);
      chk("R5 tx_ready free0", 32'(tx_ready), 0);
      wr_word(32'hDEAD_BEEF);
      chk("R7 tx_ovf", 32'(tx_ovf), 1);
      for (int i = 0; i < 8; i++) begin
         pop_tx(b);
         chk("R3 byte order", 32'(b), 32'(exp_b[i]));
      end
      chk("R7 nothing queued", 32'(tx_empty), 1);
      pop_tx(b);
      chk("R9 tx_byte zero", 32'(b), 0);
      chk("R9 tx_unf", 32'(tx_unf), 1);
      repeat (3) @(negedge clk);
      chk("R10 tx_ovf held", 32'(tx_ovf), 1);
      chk("R10 tx_unf held", 32'(tx_unf), 1);
   endtask

   task automatic t_flush();
      wr_word(32'h1234_5678);
      flush_go = 1'b1;
      @(negedge clk);
      flush_go = 1'b0;
      chk("R11 busy set", 32'(flush_busy), 1);
      @(negedge clk);
      chk("R11 busy cleared", 32'(flush_busy), 0);
      chk("R11 tx emptied", 32'(tx_empty), 1);
      chk("R11 flags cleared", {30'd0, tx_ovf, tx_unf}, 0);
   endtask

   task automatic t_wide_rx();
      logic [31:0] v;
      wide_mode = 1'b1; rd_thr = 3'd3;
      push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
      chk("R6 rx_empty partial", 32'(rx_empty), 1);
      chk("R5 rx_ready 3", 32'(rx_ready), 0);
      rd_word(v);
      chk("R8 zero data", v, 0);
      chk("R8 rx_unf", 32'(rx_unf), 1);
      push_rx(8'hA4);
      chk("R5 rx_ready 4", 32'(rx_ready), 1);
      rd_word(v);
      chk("R4 wide packing", v, 32'hA4A3_A2A1);
      chk("R6 rx_empty drained", 32'(rx_empty), 1);
   endtask

   task automatic t_byte_rx();
      logic [31:0] v;
      do_soft_reset();
      chk("R1 soft reset clears rx_unf", 32'(rx_unf), 0);
      wide_mode = 1'b0; rd_thr = 3'd0;
      for (int i = 1; i <= 8; i++) push_rx(8'(i));
      chk("R6 rx_full", 32'(rx_full), 1);
      push_rx(8'h99);
      chk("R9 rx_ovf", 32'(rx_ovf), 1);
      rd_word(v);
      chk("R4 byte read", v, 32'h0000_0001);
      for (int i = 2; i <= 8; i++) rd_word(v);
      chk("R9 overflow byte dropped", v, 32'h0000_0008);
      chk("R6 rx_empty", 32'(rx_empty), 1);
      chk("R10 rx_ovf held", 32'(rx_ovf), 1);
      do_soft_reset();
      chk("R1 soft reset clears rx_ovf", 32'(rx_ovf), 0);
      t_reset();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_byte_tx();
      t_wide_tx();
      t_flush();
      t_wide_rx();
      t_byte_rx();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CYC * 100000);
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule